// File: doc/BRIEF.md
# Centisecond Stopwatch with Decimal Rollover Interrupts

This block is a stopwatch that counts in hundredths of a second. A 100 Hz strobe arrives from outside. Each accepted strobe advances two packed BCD digits, one for hundredths and one for tenths. The block also raises three interrupt causes: one for every counted strobe (100 Hz), one each time the hundredths digit rolls over (10 Hz), and one each time the whole count rolls over (1 Hz).

Each cause has a sticky flag and an enable bit. The flags set whether or not they are enabled. Software clears a flag by writing a 1 to its bit. The interrupt line is the OR of all flags that are both set and enabled.

Counting is controlled by a two-state run controller, `ST_STOPPED` and `ST_RUNNING`. The `GO` transition (`ST_STOPPED` to `ST_RUNNING`) is taken when `run_i` is high at a clock edge. The `HALT` transition (`ST_RUNNING` to `ST_STOPPED`) is taken when `run_i` is low at a clock edge. A strobe is counted only while the controller is in `ST_RUNNING`.

Software reaches the block through a plain register port. An address selects the register, a one-cycle write strobe writes it, and read data follows the address combinationally. The map is: address 0 holds the count, address 1 the mask, address 2 the flags, and address 3 is unused.

Top module: `centi_stopwatch`

## Requirements
- R1: The register at address 0 reads the count: bits 7:4 hold the tenths digit and bits 3:0 the hundredths digit, each always 0 to 9. Each counted strobe adds one hundredth, carrying into tenths, and 99 is followed by 00. The new value is readable the cycle after the strobe.
- R2: After reset both digits, the mask, the flags and `irq_o` are all 0, and the run controller is in `ST_STOPPED`.
- R3: The count register is read-only: a write to address 0 leaves the count unchanged.
- R4: The run controller takes `GO` when `run_i` is high at an edge and `HALT` when it is low. A `tick_i` pulse is counted only if the controller is already in `ST_RUNNING` in that cycle, so counting starts one cycle after `run_i` rises.
- R5: A high `clear_i` sets both digits to 0 at the next edge and leaves the flags unchanged. A strobe in the same cycle is neither counted nor raises any cause.
- R6: Flag register at address 2: bit 0 sets on every counted strobe, bit 1 when the hundredths digit wraps from 9 to 0, and bit 2 when the count wraps from 99 to 00. Flags set regardless of the mask.
- R7: Writing 1 to a bit of the flag register clears that flag, and writing 0 leaves it unchanged. If a cause and a clearing write reach the same flag in the same cycle, the flag stays set.
- R8: The mask register at address 1 is read/write in bits 2:0. Each bit enables the flag at the same bit position.
- R9: Bits 7:3 of the mask and flag registers always read 0, and address 3 reads 0.
- R10: `irq_o` is high exactly when some flag is set and its mask bit is 1. It follows the registered flags and mask, so it rises the cycle after the event or mask write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 100 Hz strobe, one cycle wide |
| run_i | input | 1 | Run request, sampled by the run controller |
| clear_i | input | 1 | Synchronous clear of both digits |
| addr_i | input | 2 | Register select |
| wr_en_i | input | 1 | Single-cycle write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions check the following on every cycle:
- Each digit stays in the 0 to 9 range and returns to 0 after a carry.
- The stopped controller never produces a count step.
- A raised cause always leaves its flag set, and a 1 written with no competing cause always leaves its flag clear.
- Flags are stable when nothing touches them.
- A clear leaves the count at zero, and a count-register write leaves it untouched.
- Reserved read bits are zero, and an all-zero mask keeps the interrupt low.

Only the bench's scenarios can show the full sequence of decimal values across many wraps, the one-cycle delay of the run controller, and the collision of a cause with a clearing write. The same applies to the exact cycle in which `irq_o` follows a mask write.

// File: rtl/cs_pkg.sv
package cs_pkg;
    localparam int DIGIT_W = 4;
    localparam int DIGIT_MAX = 9;

    typedef enum logic {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_e;

    localparam logic [1:0] A_COUNT = 2'd0;
    localparam logic [1:0] A_MASK  = 2'd1;
    localparam logic [1:0] A_FLAG  = 2'd2;
endpackage

// File: rtl/cs_run_ctrl.sv
module cs_run_ctrl
    import cs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    input  logic clr_i,
    output logic step_o
);
    run_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: if (run_i)  state_d = ST_RUNNING;   // GO
            ST_RUNNING: if (!run_i) state_d = ST_STOPPED;   // HALT
            default:    state_d = ST_STOPPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        step_o = 1'b0;
        unique case (state_q)
            ST_STOPPED: step_o = 1'b0;
            ST_RUNNING: step_o = tick_i && !clr_i;
            default:    step_o = 1'b0;
        endcase
    end

    // R4: a stopped controller never advances the count
    p_halt_no_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPED) |-> !step_o);
    // R4: state follows the run request one edge later
    p_state_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |=> (state_q == ST_RUNNING));
endmodule

// File: rtl/cs_bcd_digit.sv
module cs_bcd_digit #(
    parameter int W    = 4,
    parameter int MAXV = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] val_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] TOP = W'(MAXV);

    logic [W-1:0] val_q;

    assign wrap_o = inc_i && (val_q == TOP);
    assign val_o  = val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      val_q <= '0;
        else if (clr_i)  val_q <= '0;
        else if (wrap_o) val_q <= '0;
        else if (inc_i)  val_q <= val_q + 1'b1;
    end

    // R1: a digit never leaves its decimal range
    p_digit_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        val_q <= TOP);
    // R1: a carry-out returns the digit to zero
    p_digit_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (val_q == '0));
endmodule

// File: rtl/cs_digit_chain.sv
module cs_digit_chain
    import cs_pkg::*;
#(
    parameter int NUM_DIGITS = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr_i,
    input  logic                          step_i,
    output logic [NUM_DIGITS*DIGIT_W-1:0] count_o,
    output logic [NUM_DIGITS:0]           cause_o
);
    logic [NUM_DIGITS:0]   carry;
    logic [NUM_DIGITS-1:0] wrap;

    assign carry[0]   = step_i;
    assign cause_o[0] = step_i;

    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
        cs_bcd_digit #(.W(DIGIT_W), .MAXV(DIGIT_MAX)) u_digit (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clr_i),
            .inc_i (carry[k]),
            .val_o (count_o[k*DIGIT_W +: DIGIT_W]),
            .wrap_o(wrap[k])
        );
        assign carry[k+1]   = wrap[k];
        assign cause_o[k+1] = wrap[k];
    end
endmodule

// File: rtl/cs_irq_bank.sv
module cs_irq_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_mask_i,
    input  logic         wr_flag_i,
    input  logic [N-1:0] wdata_i,
    input  logic [N-1:0] cause_i,
    output logic [N-1:0] mask_o,
    output logic [N-1:0] flag_o,
    output logic         irq_o
);
    logic [N-1:0] mask_q, flag_q, w1c;

    assign w1c = wr_flag_i ? wdata_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            flag_q <= '0;
        end else begin
            if (wr_mask_i) mask_q <= wdata_i;
            flag_q <= (flag_q & ~w1c) | cause_i;
        end
    end

    assign mask_o = mask_q;
    assign flag_o = flag_q;
    assign irq_o  = |(flag_q & mask_q);

    // R6: a raised cause always leaves its flag set (set wins, R7)
    p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_i != '0) |=> ((flag_o & $past(cause_i)) == $past(cause_i)));
    // R7: an uncontested write-1 clears the flag
    p_w1c_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag_i && ((wdata_i & ~cause_i) != '0))
        |=> ((flag_o & $past(wdata_i & ~cause_i)) == '0));
    // R7: flags hold when neither a cause nor a write touches them
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_flag_i && (cause_i == '0)) |=> $stable(flag_o));
    // R10: nothing enabled means no request
    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o == '0) |-> !irq_o);
endmodule

// File: rtl/centi_stopwatch.sv
module centi_stopwatch
    import cs_pkg::*;
#(
    parameter int NUM_DIGITS = 2,
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              run_i,
    input  logic              clear_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    localparam int CNT_W      = NUM_DIGITS * DIGIT_W;
    localparam int NUM_CAUSES = NUM_DIGITS + 1;

    logic                  step;
    logic [CNT_W-1:0]      count;
    logic [NUM_CAUSES-1:0] cause, mask, flag;
    logic                  wr_mask, wr_flag;

    assign wr_mask = wr_en_i && (addr_i == ADDR_W'(A_MASK));
    assign wr_flag = wr_en_i && (addr_i == ADDR_W'(A_FLAG));

    cs_run_ctrl u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (run_i),
        .tick_i(tick_i),
        .clr_i (clear_i),
        .step_o(step)
    );

    cs_digit_chain #(.NUM_DIGITS(NUM_DIGITS)) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clear_i),
        .step_i (step),
        .count_o(count),
        .cause_o(cause)
    );

    cs_irq_bank #(.N(NUM_CAUSES)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_mask_i(wr_mask),
        .wr_flag_i(wr_flag),
        .wdata_i  (wr_data_i[NUM_CAUSES-1:0]),
        .cause_i  (cause),
        .mask_o   (mask),
        .flag_o   (flag),
        .irq_o    (irq_o)
    );

    always_comb begin
        rd_data_o = '0;
        case (addr_i)
            ADDR_W'(A_COUNT): rd_data_o[CNT_W-1:0]      = count;
            ADDR_W'(A_MASK):  rd_data_o[NUM_CAUSES-1:0] = mask;
            ADDR_W'(A_FLAG):  rd_data_o[NUM_CAUSES-1:0] = flag;
            default:          rd_data_o = '0;
        endcase
    end

    // R5: a clear empties the count at the next edge
    p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (count == '0));
    // R3: a write aimed at the count register does not change it
    p_count_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (addr_i == ADDR_W'(A_COUNT)) && !step && !clear_i)
        |=> $stable(count));
    // R9: reserved bits above the cause field read zero
    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i != ADDR_W'(A_COUNT)) |-> (rd_data_o[DATA_W-1:NUM_CAUSES] == '0));
endmodule

// File: tb/centi_stopwatch_bench.sv
`timescale 1ns/1ps
module centi_stopwatch_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0, run_i = 1'b0, clear_i = 1'b0, wr_en_i = 1'b0;
    logic [1:0] addr_i = 2'd0;
    logic [7:0] wr_data_i = 8'd0;
    logic [7:0] rd_data_o;
    logic       irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int       m_cnt  = 0;
    bit [2:0] m_mask = 3'b0;
    bit [2:0] m_flag = 3'b0;
    bit       m_run  = 1'b0;

    always #4 clk = ~clk;

    centi_stopwatch u_centi_stopwatch (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run_i),
        .clear_i(clear_i), .addr_i(addr_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    function automatic logic [7:0] bcd_of(input int c);
        return 8'(((c / 10) << 4) | (c % 10));
    endfunction

    function automatic logic [7:0] exp_read(input int a);
        case (a)
            0: return bcd_of(m_cnt);
            1: return {5'b0, m_mask};
            2: return {5'b0, m_flag};
            default: return 8'h00;
        endcase
    endfunction

    task automatic cmp(input string ctx, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got=%h exp=%h", ctx, what, got, exp);
        end
    endtask

    // called just after a falling edge
    task automatic check_all(input string ctx);
        string nm [4] = '{"R1 count", "R8 mask", "R6 flags", "R9 unused"};
        for (int a = 0; a < 4; a++) begin
            addr_i = 2'(a);
            #0.5;
            cmp(ctx, nm[a], rd_data_o, exp_read(a));
        end
        cmp(ctx, "R10 irq", {7'b0, irq_o}, {7'b0, |(m_flag & m_mask)});
    endtask

    task automatic step(input bit tk, input bit rn, input bit cl, input bit we,
                        input logic [1:0] ad, input logic [7:0] wd, input string ctx);
        bit       st;
        bit [2:0] cz;
        bit [2:0] clr_bits;
        tick_i = tk; run_i = rn; clear_i = cl; wr_en_i = we;
        addr_i = ad; wr_data_i = wd;
        st = m_run && tk && !cl;
        cz[0] = st;
        cz[1] = st && (m_cnt % 10 == 9);
        cz[2] = st && (m_cnt == 99);
        clr_bits = (we && ad == 2'd2) ? wd[2:0] : 3'b0;
        m_flag = (m_flag & ~clr_bits) | cz;
        if (we && ad == 2'd1) m_mask = wd[2:0];
        if (cl)      m_cnt = 0;
        else if (st) m_cnt = (m_cnt + 1) % 100;
        m_run = rn;
        @(posedge clk);
        @(negedge clk);
        tick_i = 1'b0; clear_i = 1'b0; wr_en_i = 1'b0;
        check_all(ctx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5eed_0a17);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R2 reset");

        // R4: tick while stopped is ignored; first tick after run rises also ignored
        step(1, 0, 0, 0, 2'd0, 8'h00, "R4 stopped tick");
        step(1, 1, 0, 0, 2'd0, 8'h00, "R4 go edge tick");
        step(1, 1, 0, 0, 2'd0, 8'h00, "R4 running tick");
        // R3: write to the count register
        step(0, 1, 0, 1, 2'd0, 8'hFF, "R3 write count");
        // R8 R9: mask with reserved bits written
        step(0, 1, 0, 1, 2'd1, 8'hFF, "R8 R9 mask all");
        // R7: collision of cause 0 and write-1 on bit 0
        step(1, 1, 0, 1, 2'd2, 8'h01, "R7 set wins");
        step(0, 1, 0, 1, 2'd2, 8'h00, "R7 write zero");
        step(0, 1, 0, 1, 2'd2, 8'h07, "R7 clear all");
        // R1 R6: run to 99 and wrap
        for (int i = 0; i < 100; i++) step(1, 1, 0, 0, 2'd0, 8'h00, "R1 R6 count up");
        // R5: clear with tick present, flags kept
        step(1, 1, 1, 0, 2'd0, 8'h00, "R5 clear");
        // R10: mask off then on
        step(0, 1, 0, 1, 2'd1, 8'h00, "R10 mask off");
        step(0, 1, 0, 1, 2'd1, 8'h04, "R10 mask bit2");
        // R4: halt
        step(0, 0, 0, 0, 2'd0, 8'h00, "R4 halt");
        step(1, 0, 0, 0, 2'd0, 8'h00, "R4 halted tick");

        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 2) == 0, ($urandom % 10) != 0, ($urandom % 40) == 0,
                 ($urandom % 4) == 0, 2'($urandom % 4), 8'($urandom),
                 "R1 R5 R6 R7 R8 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule